// File: doc/BRIEF.md
# Disk Sector Header Read Sequencer

This block is the receive-side front end that locates and captures a sector header in a serial disk read stream. After it sees a sector pulse it expects a fixed sequence of encoded bits: a long run of zeros, a single sync one, a fixed number of header words, and a trailing run of zero gap bits. It counts the zeros, opens a read gate once part of the run has gone by, shifts in the header words, and checks the gap. A clean sequence ends with a one-cycle header-valid strobe. Any misplaced one or broken line code ends it with a one-cycle error strobe. In both cases the block goes back to waiting for the next sector pulse.

Each bit cell spans two strobes of the data clock enable. The first strobe samples a clock window and the second samples a data window. The data window carries the bit level. The clock window is high only when a zero follows another zero. Seen per cell, a one therefore appears as a high level, a zero after a one as a low level, and a zero after a zero as a high level again. The decoder tracks the previous bit so that it can check the clock window. A free-running divider also produces a control tick on every fourth data clock strobe.

Top module: `hdr_rd_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_gate`, `hdr_valid`, `hdr_err` and `ctl_tick` are low, `hdr_word` is zero, and the sequencer is idle. `rst` is synchronous and active high.
- R2: A header sequence starts only after `sec_pulse` has been high and then low. Bit cells sent before that, or while `sec_pulse` is still high, are ignored: neither `rd_gate` nor `hdr_err` rises.
- R3: After a start, strobes of `dclk_en` alternate between the clock window (first) and the data window (second). The bit value is the data-window level. The clock window must be high exactly when the bit is zero and the previous bit was zero, and the bit before the first one counts as zero. Any mismatch is an error.
- R4: The preamble is `PRE_LEN` zero bits (255 by default). A one received before that count is complete is an error.
- R5: `rd_gate` rises at the clock edge that takes the data-window strobe of the `GATE_AT`-th preamble zero (128 by default), and it stays high through the header and gap.
- R6: Once the preamble count is complete, further zeros are tolerated. The first one is the sync bit.
- R7: After sync, `NUM_WORDS` words of `WORD_W` bits (3 x 16 by default) are shifted in MSB first. The first word received lands in the most significant slice of `hdr_word`.
- R8: After the header, `GAP_LEN` zero bits (64 by default) are required. A one in the gap is an error.
- R9: At the edge that takes the last gap bit, `hdr_valid` pulses high for exactly one cycle, `rd_gate` falls, and `hdr_word` is loaded. `hdr_word` changes at no other time.
- R10: On an error, `hdr_err` pulses high for exactly one cycle, `rd_gate` falls at the same edge, and the block waits for a new sector pulse before it accepts any further bits.
- R11: `ctl_tick` is high in the same cycle as every `CTL_DIV`-th `dclk_en` strobe counted since reset (every fourth by default), whatever the sequencer state.
- R12: Activity on `sec_pulse` while a sequence is in progress has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk_en | input | 1 | Data clock enable strobe, one per half bit cell |
| line_in | input | 1 | Encoded serial read level |
| sec_pulse | input | 1 | Sector pulse level |
| ctl_tick | output | 1 | Control tick, every CTL_DIV-th strobe |
| rd_gate | output | 1 | Read gate |
| hdr_word | output | NUM_WORDS*WORD_W | Captured header words, first word in the most significant slice |
| hdr_valid | output | 1 | One-cycle strobe for a header that completed cleanly |
| hdr_err | output | 1 | One-cycle error strobe |

## Verification
`ctl_tick` is combinational, so it is due in the same cycle as its strobe. The bench samples it one nanosecond after driving the strobe. `rd_gate`, `hdr_valid`, `hdr_err` and `hdr_word` are registered, so each one is due at the rising edge that takes a bit's data-window strobe. The bench samples them at the following falling edge, and it samples the strobes once more a cycle later to confirm that each lasts only one cycle. A sector start takes effect at the edge where `sec_pulse` is first seen low, and the bench sends its first cell only after that edge.

// File: rtl/hdr_rd_pkg.sv
package hdr_rd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_PRE,
      ST_SYNC,
      ST_HDR,
      ST_GAP
   } rd_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/hdr_rd_lvl_dec.sv
module hdr_rd_lvl_dec (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic dclk_en,
   input  logic line_in,
   output logic bit_vld,
   output logic bit_val,
   output logic code_err
);
   logic phase_q;
   logic clkwin_q;
   logic prev_q;
   logic want_clk;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         phase_q  <= 1'b0;
         clkwin_q <= 1'b0;
         prev_q   <= 1'b0;
      end else if (dclk_en) begin
         phase_q <= ~phase_q;
         if (!phase_q) clkwin_q <= line_in;
         else          prev_q   <= line_in;
      end
   end

   always_comb begin
      want_clk = ~prev_q & ~line_in;
      bit_vld  = dclk_en & phase_q;
      bit_val  = line_in;
      code_err = bit_vld & (clkwin_q != want_clk);
   end
endmodule

// File: rtl/hdr_rd_ctl_div.sv
module hdr_rd_ctl_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = en;
      end else begin : g_cnt
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)                           cnt_q <= '0;
            else if (en && cnt_q == DW'(DIV-1)) cnt_q <= '0;
            else if (en)                       cnt_q <= cnt_q + 1'b1;
         end
         assign tick = en && (cnt_q == DW'(DIV-1));
      end
   endgenerate
endmodule

// File: rtl/hdr_rd_fsm.sv
module hdr_rd_fsm
   import hdr_rd_pkg::*;
#(
   parameter int PRE_LEN   = 255,
   parameter int GATE_AT   = 128,
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 3,
   parameter int GAP_LEN   = 64,
   localparam int HW       = WORD_W * NUM_WORDS,
   localparam int CW       = $clog2(max3(PRE_LEN, HW, GAP_LEN) + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sec_pulse,
   input  logic          bit_vld,
   input  logic          bit_val,
   input  logic          code_err,
   output logic          start,
   output logic          rd_gate,
   output logic [HW-1:0] hdr_word,
   output logic          hdr_valid,
   output logic          hdr_err
);
   rd_state_e     state_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic [HW-1:0] shift_q;
   logic          bad;

   always_comb begin
      start  = (state_q == ST_ARMED) && !sec_pulse;
      cnt_nx = cnt_q + 1'b1;
      bad    = code_err || (bit_val && (state_q == ST_PRE || state_q == ST_GAP));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         rd_gate   <= 1'b0;
         shift_q   <= '0;
         hdr_word  <= '0;
         hdr_valid <= 1'b0;
         hdr_err   <= 1'b0;
      end else begin
         hdr_valid <= 1'b0;
         hdr_err   <= 1'b0;
         case (state_q)
            ST_IDLE: if (sec_pulse) state_q <= ST_ARMED;
            ST_ARMED: if (start) begin
               state_q <= ST_PRE;
               cnt_q   <= '0;
            end
            default: if (bit_vld) begin
               if (bad) begin
                  hdr_err <= 1'b1;
                  rd_gate <= 1'b0;
                  state_q <= ST_IDLE;
                  cnt_q   <= '0;
               end else begin
                  case (state_q)
                     ST_PRE: begin
                        cnt_q <= cnt_nx;
                        if (cnt_nx == CW'(GATE_AT)) rd_gate <= 1'b1;
                        if (cnt_nx == CW'(PRE_LEN)) begin
                           state_q <= ST_SYNC;
                           cnt_q   <= '0;
                        end
                     end
                     ST_SYNC: if (bit_val) state_q <= ST_HDR;
                     ST_HDR: begin
                        shift_q <= {shift_q[HW-2:0], bit_val};
                        cnt_q   <= cnt_nx;
                        if (cnt_nx == CW'(HW)) begin
                           state_q <= ST_GAP;
                           cnt_q   <= '0;
                        end
                     end
                     ST_GAP: begin
                        cnt_q <= cnt_nx;
                        if (cnt_nx == CW'(GAP_LEN)) begin
                           hdr_valid <= 1'b1;
                           hdr_word  <= shift_q;
                           rd_gate   <= 1'b0;
                           state_q   <= ST_IDLE;
                           cnt_q     <= '0;
                        end
                     end
                     default: state_q <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/hdr_rd_seq.sv
module hdr_rd_seq #(
   parameter int PRE_LEN   = 255,
   parameter int GATE_AT   = 128,
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 3,
   parameter int GAP_LEN   = 64,
   parameter int CTL_DIV   = 4,
   localparam int HW       = WORD_W * NUM_WORDS
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          dclk_en,
   input  logic          line_in,
   input  logic          sec_pulse,
   output logic          ctl_tick,
   output logic          rd_gate,
   output logic [HW-1:0] hdr_word,
   output logic          hdr_valid,
   output logic          hdr_err
);
   generate
      if (GATE_AT < 1 || GATE_AT > PRE_LEN) begin : g_bad_gate
         $error("hdr_rd_seq: GATE_AT must lie in 1..PRE_LEN");
      end
      if (HW < 2 || GAP_LEN < 1 || CTL_DIV < 1) begin : g_bad_size
         $error("hdr_rd_seq: header, gap or divider size out of range");
      end
   endgenerate

   logic start;
   logic bit_vld;
   logic bit_val;
   logic code_err;

   hdr_rd_ctl_div #(.DIV(CTL_DIV)) div_i (
      .clk(clk), .rst(rst), .en(dclk_en), .tick(ctl_tick)
   );

   hdr_rd_lvl_dec dec_i (
      .clk(clk), .rst(rst), .start(start), .dclk_en(dclk_en),
      .line_in(line_in), .bit_vld(bit_vld), .bit_val(bit_val),
      .code_err(code_err)
   );

   hdr_rd_fsm #(
      .PRE_LEN(PRE_LEN), .GATE_AT(GATE_AT), .WORD_W(WORD_W),
      .NUM_WORDS(NUM_WORDS), .GAP_LEN(GAP_LEN)
   ) fsm_i (
      .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .bit_vld(bit_vld),
      .bit_val(bit_val), .code_err(code_err), .start(start),
      .rd_gate(rd_gate), .hdr_word(hdr_word), .hdr_valid(hdr_valid),
      .hdr_err(hdr_err)
   );
endmodule

// File: rtl/hdr_rd_seq_chk.sv
module hdr_rd_seq_chk #(
   parameter int HW = 48
) (
   input logic          clk,
   input logic          rst,
   input logic          dclk_en,
   input logic          ctl_tick,
   input logic          rd_gate,
   input logic [HW-1:0] hdr_word,
   input logic          hdr_valid,
   input logic          hdr_err
);
   AST_TICK_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      ctl_tick |-> dclk_en); // R11
   AST_GATE_RISES_ON_BIT: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_gate) |-> $past(dclk_en)); // R5
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      hdr_valid |=> !hdr_valid); // R9
   AST_VALID_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
      hdr_valid |-> !rd_gate); // R9
   AST_WORD_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
      !$stable(hdr_word) |-> hdr_valid); // R9
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      hdr_err |=> !hdr_err); // R10
   AST_ERR_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
      hdr_err |-> !rd_gate); // R10
   AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
      !(hdr_err && hdr_valid)); // R10
endmodule

bind hdr_rd_seq hdr_rd_seq_chk #(.HW(HW)) chk_i (
   .clk(clk), .rst(rst), .dclk_en(dclk_en), .ctl_tick(ctl_tick),
   .rd_gate(rd_gate), .hdr_word(hdr_word), .hdr_valid(hdr_valid),
   .hdr_err(hdr_err)
);

// File: tb/hdr_rd_seq_tb.sv
`timescale 1ns/1ps
module hdr_rd_seq_tb_top;
   localparam int PRE = 20, GATE = 10, W = 8, N = 3, GAP = 8, DIV = 4;
   localparam int HW = W * N;

   logic clk = 1'b0, rst = 1'b1, dclk_en = 1'b0, line_in = 1'b0, sec_pulse = 1'b0;
   logic ctl_tick, rd_gate, hdr_valid, hdr_err;
   logic [HW-1:0] hdr_word;

   int checks = 0, errors = 0, strobes = 0;
   bit prev = 1'b0, done = 1'b0;
   logic [HW-1:0] last_word = '0;

   always #4 clk = ~clk;

   hdr_rd_seq #(.PRE_LEN(PRE), .GATE_AT(GATE), .WORD_W(W), .NUM_WORDS(N),
                .GAP_LEN(GAP), .CTL_DIV(DIV)) dut_i (
      .clk(clk), .rst(rst), .dclk_en(dclk_en), .line_in(line_in),
      .sec_pulse(sec_pulse), .ctl_tick(ctl_tick), .rd_gate(rd_gate),
      .hdr_word(hdr_word), .hdr_valid(hdr_valid), .hdr_err(hdr_err));

   task automatic chk(input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic half(input bit lvl);
      @(negedge clk);
      dclk_en = 1'b1;
      line_in = lvl;
      #1;
      strobes++;
      chk("R11 ctl_tick", HW'(ctl_tick), HW'((strobes % DIV) == 0));
      @(negedge clk);
      dclk_en = 1'b0;
   endtask

   task automatic send_bit(input bit b);
      half(!prev && !b);
      half(b);
      prev = b;
   endtask

   task automatic send_bad(input bit b);
      half(!(!prev && !b));
      half(b);
      prev = b;
   endtask

   task automatic sector();
      @(negedge clk); sec_pulse = 1'b1;
      @(negedge clk); sec_pulse = 1'b0;
      @(negedge clk);
      prev = 1'b0;
   endtask

   task automatic expect_err(input string tag);
      chk({tag, " hdr_err"}, HW'(hdr_err), HW'(1));
      chk({tag, " rd_gate low"}, HW'(rd_gate), HW'(0));
      chk({tag, " hdr_valid"}, HW'(hdr_valid), HW'(0));
      @(negedge clk);
      chk("R10 err one cycle", HW'(hdr_err), HW'(0));
      chk("R9 word held after error", hdr_word, last_word);
   endtask

   task automatic run_hdr(input logic [HW-1:0] words, input int extra, input bit poke);
      sector();
      for (int i = 0; i < PRE; i++) begin
         if (poke && i == 3) sec_pulse = 1'b1;
         if (poke && i == 6) sec_pulse = 1'b0;
         send_bit(1'b0);
         chk("R5 gate in preamble", HW'(rd_gate), HW'((i + 1) >= GATE));
         chk("R4 no error in preamble", HW'(hdr_err), HW'(0));
      end
      for (int i = 0; i < extra; i++) begin
         send_bit(1'b0);
         chk("R6 extra zero tolerated", HW'(hdr_err), HW'(0));
      end
      send_bit(1'b1);
      chk("R6 sync keeps gate", HW'(rd_gate), HW'(1));
      for (int i = HW - 1; i >= 0; i--) send_bit(words[i]);
      for (int i = 0; i < GAP; i++) begin
         send_bit(1'b0);
         if (i < GAP - 1) chk("R8 no valid in gap", HW'(hdr_valid), HW'(0));
      end
      chk("R9 hdr_valid", HW'(hdr_valid), HW'(1));
      chk("R9 gate falls", HW'(rd_gate), HW'(0));
      chk("R7 hdr_word", hdr_word, words);
      chk(poke ? "R12 busy pulse ignored" : "R10 no error", HW'(hdr_err), HW'(0));
      last_word = words;
      @(negedge clk);
      chk("R9 valid one cycle", HW'(hdr_valid), HW'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 rd_gate", HW'(rd_gate), HW'(0));
      chk("R1 hdr_valid", HW'(hdr_valid), HW'(0));
      chk("R1 hdr_err", HW'(hdr_err), HW'(0));
      chk("R1 hdr_word", hdr_word, '0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 after release", HW'(rd_gate | hdr_valid | hdr_err | ctl_tick), HW'(0));

      for (int i = 0; i < 2 * GATE; i++) send_bit(i[0]);
      chk("R2 no gate before pulse", HW'(rd_gate), HW'(0));
      chk("R2 no error before pulse", HW'(hdr_err), HW'(0));
      @(negedge clk); sec_pulse = 1'b1;
      for (int i = 0; i < 2 * GATE; i++) send_bit(1'b0);
      chk("R2 pulse still high", HW'(rd_gate), HW'(0));
      sec_pulse = 1'b0;
      @(negedge clk);
      prev = 1'b0;
      for (int i = 0; i < PRE; i++) send_bit(1'b0);
      send_bit(1'b1);
      for (int i = 0; i < HW + GAP; i++) send_bit(1'b0);
      chk("R2 header after pulse", HW'(hdr_valid), HW'(1));
      last_word = '0;
      @(negedge clk);

      run_hdr(24'hA53C81, 0, 1'b0);
      run_hdr(24'hFFFFFF, 3, 1'b0);
      run_hdr(24'h000001, 0, 1'b1);
      for (int k = 0; k < HW; k += 5) run_hdr(HW'(1) << k, k % 3, 1'b0);

      for (int p = 0; p < PRE; p++) begin
         sector();
         for (int i = 0; i < p; i++) send_bit(1'b0);
         send_bit(1'b1);
         expect_err("R4 early one");
         send_bit(1'b0);
         chk("R10 idle after error", HW'(rd_gate | hdr_err), HW'(0));
      end

      for (int p = 0; p < GAP; p++) begin
         sector();
         for (int i = 0; i < PRE; i++) send_bit(1'b0);
         send_bit(1'b1);
         for (int i = 0; i < HW; i++) send_bit(1'b1);
         for (int i = 0; i < p; i++) send_bit(1'b0);
         send_bit(1'b1);
         expect_err("R8 one in gap");
      end

      sector();
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      send_bad(1'b0);
      expect_err("R3 bad clock window in preamble");

      sector();
      for (int i = 0; i < PRE; i++) send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bad(1'b0);
      expect_err("R3 bad clock window in header");

      run_hdr(24'h5AC33C, 1, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule